// File: doc/BRIEF.md
# Paired Execution Units with Age-Ordered Result Broadcast

This block holds the two functional units of an out-of-order core and the single result bus they share. A multiply unit takes a fixed number of cycles per operation and works on one operation at a time. A general unit handles the non-multiply arithmetic, logic, shift and compare operations with a shorter latency, and it can take a new operation every cycle. Each unit has its own dispatch port with a ready indication. A dispatch is taken on a clock edge where both valid and ready are high.

A finished result is parked in a one-entry holding slot at the end of its unit. In each cycle at most one parked result goes onto the broadcast bus. When both slots are occupied, the slot whose operation carries the older sequence stamp wins. Sequence stamps are compared modulo 2^SEQ_W, so a stamp that has wrapped past zero still counts as younger. The losing result stays parked, with its tag and value unchanged. While the general unit's slot is parked, that unit freezes its pipeline and drops ready.

Top module: `exec_pair`

## Requirements
- R1: After reset, `bc_valid` is 0 and both `mul_ready` and `alu_ready` are 1.
- R2: A multiply accepted on edge N, with no competing result, is broadcast in the cycle that follows edge N+MUL_LAT. Its value is the low W bits of `mul_a*mul_b`.
- R3: `mul_ready` is 0 from the edge that accepts a multiply up to the edge that ends that multiply's broadcast cycle. It is 1 again right after that edge.
- R4: A general-unit operation accepted on edge N, with no competing result, is broadcast in the cycle after edge N+ALU_LAT. The general unit accepts an operation on every edge, and back-to-back operations are broadcast in consecutive cycles.
- R5: The general-unit opcode `alu_op` encodes these operations: 0 add, 1 a-b, 2 AND, 3 OR, 4 XOR, 5 a shifted left by b[log2(W)-1:0], 6 logical right shift by the same amount, 7 signed a<b giving 1 or 0.
- R6: At most one result is broadcast per cycle. When both holding slots are full, the older result goes first. Result x is older than result y when bit SEQ_W-1 of (seq_x - seq_y) mod 2^SEQ_W is 1.
- R7: A parked result that loses arbitration keeps its tag and value. It is broadcast in the cycle after the winner.
- R8: While the general unit's holding slot is full and not granted, `alu_ready` is 0 and the general pipeline does not advance. Operations already in flight are later broadcast in order, with none lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mul_valid | input | 1 | Multiply dispatch request |
| mul_ready | output | 1 | Multiply unit can accept |
| mul_a | input | W | Multiply operand a |
| mul_b | input | W | Multiply operand b |
| mul_tag | input | TAG_W | Result tag of the multiply |
| mul_seq | input | SEQ_W | Age stamp of the multiply |
| alu_valid | input | 1 | General-unit dispatch request |
| alu_ready | output | 1 | General unit can accept |
| alu_op | input | 3 | General-unit opcode |
| alu_a | input | W | General operand a |
| alu_b | input | W | General operand b |
| alu_tag | input | TAG_W | Result tag of the general operation |
| alu_seq | input | SEQ_W | Age stamp of the general operation |
| bc_valid | output | 1 | Broadcast carries a result |
| bc_tag | output | TAG_W | Tag of the broadcast result |
| bc_value | output | W | Value of the broadcast result |

## Verification
The bench builds the block with SEQ_W=4. This lets it place age stamps on both sides of the wrap from 15 to 0 and check that the modular comparison still picks the older operation. TAG_W is raised to 5 so that every operation in a run has its own tag, and the scoreboard can match each broadcast to its expected entry by tag alone. The latencies keep their default values of 6 and 2. With those values a multiply accepted four edges before a general operation lands in the same broadcast cycle, which makes the contention and stall cases reachable.

// File: rtl/exec_pair.sv
module exec_pair #(
  parameter int W       = 32,
  parameter int TAG_W   = 4,
  parameter int SEQ_W   = 6,
  parameter int MUL_LAT = 6,
  parameter int ALU_LAT = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mul_valid,
  output logic             mul_ready,
  input  logic [W-1:0]     mul_a,
  input  logic [W-1:0]     mul_b,
  input  logic [TAG_W-1:0] mul_tag,
  input  logic [SEQ_W-1:0] mul_seq,
  input  logic             alu_valid,
  output logic             alu_ready,
  input  logic [2:0]       alu_op,
  input  logic [W-1:0]     alu_a,
  input  logic [W-1:0]     alu_b,
  input  logic [TAG_W-1:0] alu_tag,
  input  logic [SEQ_W-1:0] alu_seq,
  output logic             bc_valid,
  output logic [TAG_W-1:0] bc_tag,
  output logic [W-1:0]     bc_value
);
  localparam int CNT_W = $clog2(MUL_LAT + 1);
  localparam int SH_W  = $clog2(W);

  // multiply unit
  logic             m_run;
  logic [CNT_W-1:0] m_cnt;
  logic [W-1:0]     m_a, m_b;
  logic [TAG_W-1:0] m_tag;
  logic [SEQ_W-1:0] m_seq;
  logic             mh_v;
  logic [W-1:0]     mh_val;
  logic [TAG_W-1:0] mh_tag;
  logic [SEQ_W-1:0] mh_seq;

  // general unit
  logic [ALU_LAT-1:0] s_v;
  logic [W-1:0]       s_val [ALU_LAT];
  logic [TAG_W-1:0]   s_tag [ALU_LAT];
  logic [SEQ_W-1:0]   s_seq [ALU_LAT];
  logic               ah_v;
  logic [W-1:0]       ah_val;
  logic [TAG_W-1:0]   ah_tag;
  logic [SEQ_W-1:0]   ah_seq;
  logic [W-1:0]       f;

  // arbitration
  logic [SEQ_W-1:0] age_diff;
  logic             g_mul, g_alu, advance;

  assign age_diff  = mh_seq - ah_seq;
  assign g_mul     = mh_v && (!ah_v || age_diff[SEQ_W-1]);
  assign g_alu     = ah_v && !g_mul;
  assign advance   = !ah_v || g_alu;

  assign mul_ready = !m_run && !mh_v;
  assign alu_ready = advance;
  assign bc_valid  = g_mul || g_alu;
  assign bc_tag    = g_mul ? mh_tag : ah_tag;
  assign bc_value  = g_mul ? mh_val : ah_val;

  always_ff @(posedge clk) begin
    if (rst) begin
      m_run  <= 1'b0;
      m_cnt  <= '0;
      m_a    <= '0;
      m_b    <= '0;
      m_tag  <= '0;
      m_seq  <= '0;
      mh_v   <= 1'b0;
      mh_val <= '0;
      mh_tag <= '0;
      mh_seq <= '0;
    end else begin
      if (mul_valid && mul_ready) begin
        m_run <= 1'b1;
        m_cnt <= CNT_W'(MUL_LAT);
        m_a   <= mul_a;
        m_b   <= mul_b;
        m_tag <= mul_tag;
        m_seq <= mul_seq;
      end else if (m_run) begin
        m_cnt <= m_cnt - CNT_W'(1);
        if (m_cnt == CNT_W'(1)) begin
          m_run  <= 1'b0;
          mh_v   <= 1'b1;
          mh_val <= m_a * m_b;
          mh_tag <= m_tag;
          mh_seq <= m_seq;
        end
      end
      if (g_mul) mh_v <= 1'b0;
    end
  end

  always_comb begin
    case (alu_op)
      3'd0:    f = alu_a + alu_b;
      3'd1:    f = alu_a - alu_b;
      3'd2:    f = alu_a & alu_b;
      3'd3:    f = alu_a | alu_b;
      3'd4:    f = alu_a ^ alu_b;
      3'd5:    f = alu_a << alu_b[SH_W-1:0];
      3'd6:    f = alu_a >> alu_b[SH_W-1:0];
      default: f = {{(W-1){1'b0}}, $signed(alu_a) < $signed(alu_b)};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s_v    <= '0;
      ah_v   <= 1'b0;
      ah_val <= '0;
      ah_tag <= '0;
      ah_seq <= '0;
      for (int i = 0; i < ALU_LAT; i++) begin
        s_val[i] <= '0;
        s_tag[i] <= '0;
        s_seq[i] <= '0;
      end
    end else if (advance) begin
      s_v[0]   <= alu_valid;
      s_val[0] <= f;
      s_tag[0] <= alu_tag;
      s_seq[0] <= alu_seq;
      for (int i = 1; i < ALU_LAT; i++) begin
        s_v[i]   <= s_v[i-1];
        s_val[i] <= s_val[i-1];
        s_tag[i] <= s_tag[i-1];
        s_seq[i] <= s_seq[i-1];
      end
      ah_v   <= s_v[ALU_LAT-1];
      ah_val <= s_val[ALU_LAT-1];
      ah_tag <= s_tag[ALU_LAT-1];
      ah_seq <= s_seq[ALU_LAT-1];
    end
  end
endmodule

// File: rtl/exec_pair_chk.sv
module exec_pair_chk #(
  parameter int W     = 32,
  parameter int TAG_W = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             mul_valid,
  input logic             mul_ready,
  input logic             alu_ready,
  input logic             mh_v,
  input logic             ah_v,
  input logic             g_mul,
  input logic             g_alu,
  input logic [TAG_W-1:0] mh_tag,
  input logic [TAG_W-1:0] ah_tag,
  input logic [W-1:0]     mh_val,
  input logic [W-1:0]     ah_val
);
  AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({g_mul, g_alu})); // R6
  AST_MUL_BUSY: assert property (@(posedge clk) disable iff (rst)
    (mul_valid && mul_ready) |=> !mul_ready); // R3
  AST_MUL_HELD: assert property (@(posedge clk) disable iff (rst)
    (mh_v && !g_mul) |=> (mh_v && $stable(mh_tag) && $stable(mh_val))); // R7
  AST_ALU_HELD: assert property (@(posedge clk) disable iff (rst)
    (ah_v && !g_alu) |=> (ah_v && $stable(ah_tag) && $stable(ah_val))); // R7
  AST_ALU_STALL: assert property (@(posedge clk) disable iff (rst)
    (ah_v && !g_alu) |-> !alu_ready); // R8
endmodule

bind exec_pair exec_pair_chk #(.W(W), .TAG_W(TAG_W)) u_chk (
  .clk(clk), .rst(rst), .mul_valid(mul_valid), .mul_ready(mul_ready),
  .alu_ready(alu_ready), .mh_v(mh_v), .ah_v(ah_v), .g_mul(g_mul),
  .g_alu(g_alu), .mh_tag(mh_tag), .ah_tag(ah_tag), .mh_val(mh_val),
  .ah_val(ah_val)
);

// File: tb/exec_pair_test.sv
module exec_pair_test;
  localparam int W = 32, TW = 5, SW = 4;

  logic clk = 0, rst = 1;
  logic mul_valid = 0, alu_valid = 0;
  logic mul_ready, alu_ready, bc_valid;
  logic [W-1:0] mul_a = 0, mul_b = 0, alu_a = 0, alu_b = 0, bc_value;
  logic [TW-1:0] mul_tag = 0, alu_tag = 0, bc_tag;
  logic [SW-1:0] mul_seq = 0, alu_seq = 0;
  logic [2:0] alu_op = 0;

  exec_pair #(.W(W), .TAG_W(TW), .SEQ_W(SW), .MUL_LAT(6), .ALU_LAT(2)) uut (
    .clk(clk), .rst(rst), .mul_valid(mul_valid), .mul_ready(mul_ready),
    .mul_a(mul_a), .mul_b(mul_b), .mul_tag(mul_tag), .mul_seq(mul_seq),
    .alu_valid(alu_valid), .alu_ready(alu_ready), .alu_op(alu_op),
    .alu_a(alu_a), .alu_b(alu_b), .alu_tag(alu_tag), .alu_seq(alu_seq),
    .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_value(bc_value));

  always #5 clk = ~clk;

  typedef struct { logic [TW-1:0] tag; logic [W-1:0] val; int cyc; string req; } item_t;
  item_t q[$];
  int cyc = 0, compared = 0, mismatched = 0;
  logic [TW-1:0] ntag = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s at cycle %0d: actual %h expected %h", req, cyc, act, exp);
    end
  endtask

  task automatic push(input logic [TW-1:0] t, input logic [W-1:0] v, input int c, input string req);
    item_t it;
    it.tag = t; it.val = v; it.cyc = c; it.req = req;
    q.push_back(it);
  endtask

  function automatic logic [W-1:0] alu_ref(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b);
    case (op)
      3'd0: return a + b;
      3'd1: return a - b;
      3'd2: return a & b;
      3'd3: return a | b;
      3'd4: return a ^ b;
      3'd5: return a << b[4:0];
      3'd6: return a >> b[4:0];
      default: return ($signed(a) < $signed(b)) ? 1 : 0;
    endcase
  endfunction

  // monitor
  always @(negedge clk) begin
    int idx;
    if (!rst && bc_valid) begin
      idx = -1;
      foreach (q[i]) if (idx < 0 && q[i].tag == bc_tag) idx = i;
      if (idx < 0) chk(0, "R6 unexpected tag", W'(bc_tag), 0);
      else begin
        chk(q[idx].val == bc_value, q[idx].req, bc_value, q[idx].val);
        chk(q[idx].cyc == cyc, {q[idx].req, " cycle"}, W'(cyc), W'(q[idx].cyc));
        q.delete(idx);
      end
    end
  end

  task automatic step; @(posedge clk); @(negedge clk); endtask
  task automatic wait_cyc(input int t); while (cyc < t) step(); endtask

  task automatic drive_alu(input logic [2:0] op, input logic [W-1:0] a, input logic [W-1:0] b, input logic [SW-1:0] s);
    alu_valid = 1; alu_op = op; alu_a = a; alu_b = b; alu_tag = ntag; alu_seq = s;
    ntag = ntag + 1;
  endtask

  task automatic mul_one(input logic [W-1:0] a, input logic [W-1:0] b);
    int A;
    logic [W-1:0] p;
    p = a * b;
    A = cyc + 1;
    mul_valid = 1; mul_a = a; mul_b = b; mul_tag = ntag; mul_seq = 3;
    push(ntag, p, A + 6, "R2 mul result");
    ntag = ntag + 1;
    step(); mul_valid = 0;
    for (int k = 0; k <= 6; k++) begin
      chk(mul_ready == 0, "R3 busy", W'(mul_ready), 0);
      step();
    end
    chk(mul_ready == 1, "R3 ready again", W'(mul_ready), 1);
    wait_cyc(A + 9);
  endtask

  task automatic contend(input logic [SW-1:0] ms, input logic [SW-1:0] as, input bit mul_wins, input bit burst);
    int A;
    logic [W-1:0] x;
    A = cyc + 1;
    mul_valid = 1; mul_a = 32'h1234 + W'(ms); mul_b = 32'h10001; mul_tag = ntag; mul_seq = ms;
    push(ntag, (32'h1234 + W'(ms)) * 32'h10001, mul_wins ? A + 6 : A + 7, "R6 mul in contention");
    ntag = ntag + 1;
    step(); mul_valid = 0;
    wait_cyc(A + 3);
    x = alu_ref(3'd0, 32'd100, W'(as));
    push(ntag, x, mul_wins ? A + 7 : A + 6, "R7 alu in contention");
    drive_alu(3'd0, 32'd100, W'(as), as);
    step();
    if (burst) begin
      chk(alu_ready == 1, "R8 ready before stall", W'(alu_ready), 1);
      push(ntag, alu_ref(3'd4, 32'hF0F0, 32'h0FF0), A + 8, "R8 frozen op Y");
      drive_alu(3'd4, 32'hF0F0, 32'h0FF0, as + 1);
    end else alu_valid = 0;
    step();
    if (burst) begin
      chk(alu_ready == 1, "R8 ready before stall", W'(alu_ready), 1);
      push(ntag, alu_ref(3'd1, 32'd5, 32'd9), A + 9, "R8 frozen op Z");
      drive_alu(3'd1, 32'd5, 32'd9, as + 2);
    end
    step(); alu_valid = 0;
    chk(alu_ready == !mul_wins, "R8 ready during contention", W'(alu_ready), W'(!mul_wins));
    wait_cyc(A + 7);
    chk(mul_ready == mul_wins, "R3 ready after loss/win", W'(mul_ready), W'(mul_wins));
    wait_cyc(A + 12);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        mismatched++; compared++;
        $display("FAIL watchdog expired: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
      end
    join_none
    repeat (3) @(negedge clk);
    rst = 0;
    step();
    chk(bc_valid == 0, "R1 no broadcast", W'(bc_valid), 0);
    chk(mul_ready == 1, "R1 mul ready", W'(mul_ready), 1);
    chk(alu_ready == 1, "R1 alu ready", W'(alu_ready), 1);

    mul_one(32'd7, 32'd9);
    mul_one(32'hFFFF_FFFF, 32'h8000_0003);

    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a, b;
      a = 32'h8000_0013 + 32'h0101 * i;
      b = 32'd3 + i;
      chk(alu_ready == 1, "R4 back-to-back ready", W'(alu_ready), 1);
      push(ntag, alu_ref(3'(i), a, b), cyc + 3, "R5 opcode result");
      drive_alu(3'(i), a, b, 4'(i));
      step();
    end
    alu_valid = 0;
    push(ntag, alu_ref(3'd7, 32'd4, 32'hFFFF_FFFE), cyc + 3, "R5 signed compare");
    drive_alu(3'd7, 32'd4, 32'hFFFF_FFFE, 0);
    step(); alu_valid = 0;
    wait_cyc(cyc + 6);

    contend(4'd10, 4'd11, 1, 1);
    contend(4'd6, 4'd5, 0, 0);
    contend(4'd15, 4'd0, 1, 0);
    contend(4'd1, 4'd14, 0, 0);

    wait_cyc(cyc + 10);
    foreach (q[i]) chk(0, {q[i].req, " never broadcast"}, 0, W'(q[i].tag));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule